// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block encrypts one 128-bit block under a 128-bit key with the AES-128 cipher. It works one round per clock. A single register holds the cipher state, and a second register holds the current round key. The next round key is derived from the current one in the same cycle that the state is transformed, so no key schedule is stored.

A one-cycle strobe on `load_i` captures the plaintext and the key, applies the initial key whitening and restarts the round sequence. The strobe wins over any computation in progress. Ten clock cycles later `ready_o` goes high. From then on `ciphertext_o` carries the result, and both outputs hold until the next strobe. The S-box is computed as a GF(2^8) inverse followed by the affine map, so no table or memory file is needed.

Byte 0 of the cipher state is the most significant byte of each 128-bit word. Bytes fill the state one 4-byte column at a time.

Top module: `aes128_iter_enc`

## Requirements
- R1: With plaintext 0x00112233445566778899aabbccddeeff and key 0x000102030405060708090a0b0c0d0e0f, `ciphertext_o` equals 0x69c4e0d86a7b0430d8cdb78070b4c55a when `ready_o` is high. Byte 0 is bits 127:120 and the state is column-major.
- R2: If `load_i` is high at clock edge k and low afterwards, `ready_o` is low after edges k through k+9 and high after edge k+10.
- R3: `load_i` has priority over a computation in progress and over a finished result. `ready_o` is low after the load edge, and the result that follows belongs to the newly captured operands.
- R4: Once `ready_o` is high and `load_i` stays low, `ready_o` stays high and `ciphertext_o` stays unchanged.
- R5: For any plaintext and key, the ciphertext equals standard AES-128 encryption, with the byte order of R1.
- R6: After the asynchronous active-low reset, `ready_o` is low and stays low until a load has completed its ten rounds.
- R7: If `load_i` is held high for several cycles, `ready_o` stays low. Timing follows R2 from the last edge at which `load_i` was high, and the operands used are those present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture operands and restart the encryption |
| plaintext_i | input | 128 | Plaintext block, byte 0 in bits 127:120 |
| key_i | input | 128 | Cipher key, byte 0 in bits 127:120 |
| ciphertext_o | output | 128 | Encrypted block, valid while ready_o is high |
| ready_o | output | 1 | Result finished and held |

## Verification
The bench builds the block with its default of ten rounds, which is the only setting the cipher defines. It runs a full sweep of all 256 values of the first plaintext byte under a zero key, so every S-box input appears in the first round. It also sweeps walking-one keys and pseudo-random operands, and compares each result against an arithmetic reference model in the bench. That reference model finds S-box entries by searching for the field inverse rather than by exponentiation.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;

    localparam int unsigned BLOCK_W = 128;
    localparam int unsigned NBYTES  = BLOCK_W / 8;
    localparam int unsigned NCOLS   = 4;

    // Multiply by x in GF(2^8) with the cipher's reduction polynomial.
    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] p;
        acc = 8'h00;
        p   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = xtime(p);
        end
        return acc;
    endfunction

    // Inverse as a^254, the product of a^(2^i) for i = 1..7. The inverse of 0 is 0.
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] sq;
        logic [7:0] r;
        sq = a;
        r  = 8'h01;
        for (int i = 1; i < 8; i++) begin
            sq = gf_mul(sq, sq);
            r  = gf_mul(r, sq);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int unsigned n);
        return (v << n) | (v >> (8 - n));
    endfunction

    function automatic logic [7:0] sbox_fn(input logic [7:0] a);
        logic [7:0] b;
        b = gf_inv(a);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox (
    input  logic [7:0] in_i,
    output logic [7:0] out_o
);
    import aes_enc_pkg::*;

    always_comb begin
        out_o = sbox_fn(in_i);
    end
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step (
    input  logic [127:0] key_i,
    input  logic [7:0]   rcon_i,
    output logic [127:0] key_o
);
    import aes_enc_pkg::*;

    logic [31:0] last_w;
    logic [31:0] rot_w;
    logic [31:0] sub_w;
    logic [31:0] w0, w1, w2, w3;

    assign last_w = key_i[31:0];
    assign rot_w  = {last_w[23:0], last_w[31:24]};

    for (genvar g = 0; g < 4; g++) begin : g_sub
        aes_sbox i_sb (
            .in_i  (rot_w[8*g +: 8]),
            .out_o (sub_w[8*g +: 8])
        );
    end

    always_comb begin
        w0    = key_i[127:96] ^ sub_w ^ {rcon_i, 24'h0};
        w1    = key_i[95:64] ^ w0;
        w2    = key_i[63:32] ^ w1;
        w3    = key_i[31:0] ^ w2;
        key_o = {w0, w1, w2, w3};
    end
endmodule

// File: rtl/aes_round.sv
module aes_round (
    input  logic [127:0] state_i,
    input  logic [127:0] rkey_i,
    input  logic         last_i,
    output logic [127:0] state_o
);
    import aes_enc_pkg::*;

    logic [7:0] sub_b [NBYTES];
    logic [7:0] shf_b [NBYTES];
    logic [7:0] mix_b [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_sub
        aes_sbox i_sb (
            .in_i  (state_i[BLOCK_W-1-8*g -: 8]),
            .out_o (sub_b[g])
        );
    end

    // Row r of column c takes the byte of row r from column (c + r) mod 4.
    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        for (genvar r = 0; r < 4; r++) begin : g_row
            assign shf_b[4*c + r] = sub_b[4*((c + r) % NCOLS) + r];
        end
    end

    always_comb begin
        for (int c = 0; c < NCOLS; c++) begin
            for (int r = 0; r < 4; r++) begin
                mix_b[4*c + r] = xtime(shf_b[4*c + r])
                               ^ xtime(shf_b[4*c + (r+1)%4]) ^ shf_b[4*c + (r+1)%4]
                               ^ shf_b[4*c + (r+2)%4]
                               ^ shf_b[4*c + (r+3)%4];
            end
        end
        for (int i = 0; i < NBYTES; i++) begin
            state_o[BLOCK_W-1-8*i -: 8] = (last_i ? shf_b[i] : mix_b[i])
                                        ^ rkey_i[BLOCK_W-1-8*i -: 8];
        end
    end
endmodule

// File: rtl/aes128_iter_enc.sv
module aes128_iter_enc #(
    parameter int unsigned NUM_ROUNDS = 10
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [127:0] plaintext_i,
    input  logic [127:0] key_i,
    output logic [127:0] ciphertext_o,
    output logic         ready_o
);
    import aes_enc_pkg::*;

    localparam int unsigned CNT_W = $clog2(NUM_ROUNDS + 1);

    typedef struct packed {
        logic [BLOCK_W-1:0] state;
        logic [BLOCK_W-1:0] rkey;
        logic [7:0]         rcon;
        logic [CNT_W-1:0]   done_rounds;
        logic               busy;
        logic               ready;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [BLOCK_W-1:0] key_next;
    logic [BLOCK_W-1:0] state_next;
    logic               last_round;

    assign last_round = (eng_q.done_rounds == CNT_W'(NUM_ROUNDS - 1));

    aes_key_step i_key_step (
        .key_i  (eng_q.rkey),
        .rcon_i (eng_q.rcon),
        .key_o  (key_next)
    );

    aes_round i_round (
        .state_i (eng_q.state),
        .rkey_i  (key_next),
        .last_i  (last_round),
        .state_o (state_next)
    );

    always_comb begin
        eng_d = eng_q;
        if (load_i) begin
            eng_d.state       = plaintext_i ^ key_i;
            eng_d.rkey        = key_i;
            eng_d.rcon        = 8'h01;
            eng_d.done_rounds = '0;
            eng_d.busy        = 1'b1;
            eng_d.ready       = 1'b0;
        end else if (eng_q.busy) begin
            eng_d.state       = state_next;
            eng_d.rkey        = key_next;
            eng_d.rcon        = xtime(eng_q.rcon);
            eng_d.done_rounds = eng_q.done_rounds + 1'b1;
            if (last_round) begin
                eng_d.busy  = 1'b0;
                eng_d.ready = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign ciphertext_o = eng_q.state;
    assign ready_o      = eng_q.ready;
endmodule

// File: rtl/aes128_iter_enc_chk.sv
module aes128_iter_enc_chk #(
    parameter int unsigned NUM_ROUNDS = 10
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         load_i,
    input logic [127:0] ciphertext_o,
    input logic         ready_o
);
    localparam int unsigned CNT_W = $clog2(NUM_ROUNDS + 1);

    logic [CNT_W-1:0] since_load;
    logic             seen_load;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_load <= '0;
            seen_load  <= 1'b0;
        end else if (load_i) begin
            since_load <= '0;
            seen_load  <= 1'b1;
        end else if (since_load != CNT_W'(NUM_ROUNDS)) begin
            since_load <= since_load + 1'b1;
        end
    end

    // R2 and R7: ready exactly when ten cycles have passed since the last load edge
    a_r2_ready_after_rounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seen_load |-> (ready_o == (since_load == CNT_W'(NUM_ROUNDS))));

    // R3: a load always clears ready on the next cycle
    a_r3_load_clears_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> !ready_o);

    // R4: a finished result holds without a load
    a_r4_result_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && !load_i) |=> (ready_o && $stable(ciphertext_o)));

    // R6: no result before the first load
    a_r6_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !seen_load |-> !ready_o);
endmodule

bind aes128_iter_enc aes128_iter_enc_chk #(.NUM_ROUNDS(NUM_ROUNDS)) i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_i),
    .ciphertext_o (ciphertext_o),
    .ready_o      (ready_o)
);

// File: tb/test_aes128_iter_enc.sv
module test_aes128_iter_enc;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [127:0] pt = '0;
    logic [127:0] key = '0;
    logic [127:0] ct;
    logic         ready;

    int errors = 0;
    int checks = 0;
    logic [7:0] sb [256];

    always #10 clk = ~clk;

    aes128_iter_enc i_aes128_iter_enc (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .load_i       (load),
        .plaintext_i  (pt),
        .key_i        (key),
        .ciphertext_o (ct),
        .ready_o      (ready)
    );

    function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] prod;
        prod = '0;
        for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (prod[i]) prod = prod ^ (16'h011b << (i - 8));
        return prod[7:0];
    endfunction

    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv;
            logic [7:0] s;
            inv = 8'h00;
            for (int y = 1; y < 256; y++) if (mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
            sb[x] = s ^ 8'h63;
        end
    endtask

    function automatic logic [127:0] ref_enc(input logic [127:0] p, input logic [127:0] k0);
        logic [7:0] s [16];
        logic [7:0] k [16];
        logic [7:0] t [16];
        logic [7:0] rc;
        logic [127:0] res;
        for (int i = 0; i < 16; i++) begin
            k[i] = k0[127-8*i -: 8];
            s[i] = p[127-8*i -: 8] ^ k[i];
        end
        rc = 8'h01;
        for (int r = 1; r <= 10; r++) begin
            k[0] = k[0] ^ sb[k[13]] ^ rc;
            k[1] = k[1] ^ sb[k[14]];
            k[2] = k[2] ^ sb[k[15]];
            k[3] = k[3] ^ sb[k[12]];
            for (int i = 4; i < 16; i++) k[i] = k[i] ^ k[i-4];
            rc = mul(rc, 8'h02);
            for (int c = 0; c < 4; c++)
                for (int w = 0; w < 4; w++) t[w + 4*c] = sb[s[w + 4*((c + w) % 4)]];
            if (r < 10) begin
                for (int c = 0; c < 4; c++)
                    for (int w = 0; w < 4; w++)
                        s[4*c + w] = mul(8'h02, t[4*c + w]) ^ mul(8'h03, t[4*c + (w+1)%4])
                                   ^ t[4*c + (w+2)%4] ^ t[4*c + (w+3)%4];
            end else begin
                for (int i = 0; i < 16; i++) s[i] = t[i];
            end
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ k[i];
        end
        for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
        return res;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Load at the next edge, then release; returns at the negedge after the load edge.
    task automatic do_load(input logic [127:0] p, input logic [127:0] k);
        @(negedge clk);
        load = 1'b1;
        pt   = p;
        key  = k;
        @(negedge clk);
        load = 1'b0;
        pt   = ~p;
        key  = ~k;
    endtask

    task automatic run_vec(input logic [127:0] p, input logic [127:0] k, input string req,
                           input bit check_timing);
        logic [127:0] exp;
        exp = ref_enc(p, k);
        do_load(p, k);
        repeat (9) @(negedge clk);
        if (check_timing) check(ready == 1'b0, "R2 early", 128'(ready), 128'(0));
        @(negedge clk);
        check(ready == 1'b1, {req, " ready"}, 128'(ready), 128'(1));
        check(ct == exp, req, ct, exp);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 128'(0), 128'(1));
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [127:0] held;
        logic [127:0] lfsr;
        build_sbox();
        repeat (3) @(negedge clk);
        check(ready == 1'b0, "R6 in reset", 128'(ready), 128'(0));
        rst_n = 1'b1;
        repeat (15) @(negedge clk);
        check(ready == 1'b0, "R6 idle", 128'(ready), 128'(0));

        // R1: published vector
        check(ref_enc(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f)
              == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1 model",
              ref_enc(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f),
              128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        run_vec(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
                "R1", 1'b1);
        check(ct == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1 literal", ct,
              128'h69c4e0d86a7b0430d8cdb78070b4c55a);

        // R4: hold for 20 cycles
        held = ct;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(ready == 1'b1 && ct == held, "R4 hold", ct, held);
        end

        // R3: reload while ready is high
        do_load(128'h0, 128'h0);
        check(ready == 1'b0, "R3 drop on reload", 128'(ready), 128'(0));
        repeat (4) @(negedge clk);
        // R3: reload mid-computation with different operands
        run_vec(128'hfedcba98765432100123456789abcdef, 128'h2b7e151628aed2a6abf7158809cf4f3c,
                "R3 restart", 1'b1);

        // R7: load held high for three edges
        @(negedge clk);
        load = 1'b1; pt = 128'h1; key = 128'h2;
        @(negedge clk);
        check(ready == 1'b0, "R7 held", 128'(ready), 128'(0));
        pt = 128'h3; key = 128'h4;
        @(negedge clk);
        pt = 128'h5; key = 128'h6;
        @(negedge clk);
        load = 1'b0; pt = '0; key = '0;
        repeat (9) @(negedge clk);
        check(ready == 1'b0, "R7 early", 128'(ready), 128'(0));
        @(negedge clk);
        check(ready == 1'b1 && ct == ref_enc(128'h5, 128'h6), "R7 result", ct,
              ref_enc(128'h5, 128'h6));

        // R5: every value of plaintext byte 0 under a zero key
        for (int v = 0; v < 256; v++)
            run_vec({8'(v), 120'h0}, 128'h0, "R5 byte sweep", v < 4);
        // R5: walking-one key
        for (int b = 0; b < 128; b += 7)
            run_vec(128'hdeadbeefcafef00d0123456789abcdef, 128'h1 << b, "R5 key sweep", 1'b0);
        // R5: pseudo-random operands
        lfsr = 128'h3243f6a8885a308d313198a2e0370734;
        for (int n = 0; n < 24; n++) begin
            lfsr = {lfsr[126:0], lfsr[127] ^ lfsr[125] ^ lfsr[100] ^ lfsr[98]};
            run_vec(lfsr, {lfsr[63:0], lfsr[127:64]} ^ 128'h5a5a, "R5 random", 1'b1);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule